// File: doc/BRIEF.md
# Power-Down Sequencer with Wake Stabilisation

This block controls how the chip enters and leaves its low-power state. Software programs a single control word through a write strobe. That word holds the oscillator enables, the sleep request, the entry mode, the wake-delay enable, the wake interrupt enable and the system clock source. All of these bits except the wake flag accept writes only while the unlock input is high. The current state of the word can be read at any time on `rd_data`.

Sleep can start as soon as the request bit is set, or it can wait until the processor reports that it is idle on `cpu_sleep`. In the low-power state the fast oscillators, the PLL and the system clock are gated off, and the slow oscillators keep running.

The wake-up inputs are OR-reduced and passed through a two-flop synchroniser. A wake event sets the wake flag and ends the low-power state. It also clears the sleep request bit. If the wake-delay enable is set, the system clock stays off while a counter runs. The counter advances only on ticks of the selected fast source and needs a longer count for the crystal than for the RC oscillator.

Top module: `pdn_seq`

## Requirements
- R1: With the request bit (bit 7) set and the wait-for-CPU bit (bit 8) clear, the block enters the low-power state without waiting for `cpu_sleep`.
- R2: With the wait-for-CPU bit set, the block enters the low-power state only after the request bit is set and `cpu_sleep` is high. Until then `sysclk_en` stays 1.
- R3: A wake from the low-power state clears the request bit, and the read value of bit 7 is then 0.
- R4: In the low-power state, `hxt_en`, `hirc_en`, `pll_en` and `sysclk_en` are 0. `lxt_en` and `lirc_en` keep following their enable bits (bits 1 and 3).
- R5: With wake delay enabled (bit 4) and the crystal selected (bit 9 = 0), `sysclk_en` returns exactly DLY_LONG (4096) `hxt_tick` pulses after the delay starts.
- R6: With the RC oscillator selected (bit 9 = 1), the delay is DLY_SHORT (256) `hirc_tick` pulses. Ticks from the unselected source do not advance the delay.
- R7: With wake delay disabled, `sysclk_en` and `sysclk_rdy` return within a few cycles of a wake event.
- R8: A pulse on any bit of `wake_evt` sets the wake flag (bit 6). Writing 1 to bit 6 clears the flag, and no unlock is needed for this.
- R9: `wake_irq` is 1 exactly when the wake flag and the wake interrupt enable (bit 5) are both 1.
- R10: Writes with `unlock` low leave bits 0-5 and 7-9 unchanged.
- R11: A wake event while the block is waiting for `cpu_sleep` cancels the entry and clears the request bit. A later `cpu_sleep` then has no effect.
- R12: After reset, `rd_data` reads 0x204: the RC oscillator is enabled and selected, and every other bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 10 | Write data for the control word |
| unlock | input | 1 | Write-protect unlock; protected bits change only while it is high |
| rd_data | output | 10 | Current control word |
| cpu_sleep | input | 1 | Processor idle (wait-for-interrupt) indication |
| wake_evt | input | N_WAKE | Asynchronous wake-up event lines |
| hxt_tick | input | 1 | Clock-enable pulse modelling the crystal oscillator |
| hirc_tick | input | 1 | Clock-enable pulse modelling the fast RC oscillator |
| hxt_en | output | 1 | Crystal oscillator enable |
| lxt_en | output | 1 | Slow crystal enable |
| hirc_en | output | 1 | Fast RC oscillator enable |
| lirc_en | output | 1 | Slow RC oscillator enable |
| pll_en | output | 1 | PLL enable |
| sysclk_en | output | 1 | System clock gate |
| sysclk_rdy | output | 1 | System clock stable indication |
| wake_irq | output | 1 | Wake-up interrupt |

## Verification
On every cycle, the assertions check the state transitions for immediate entry, for waiting on the processor and for cancelling a pending entry. They also check that the request bit clears on wake and that the flag sets on a synchronised event. Locked writes must leave the protected bits stable, and the delay counter must stay within bound. The exact stabilisation lengths can only be shown by the bench's scenarios, which count cycles from the ports. The same holds for the sweep over every wake line, the clearing of the flag and the interrupt, and the absence of progress on ticks from the wrong source.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

    typedef struct packed {
        logic src_hirc;   // bit 9
        logic wait_cpu;   // bit 8
        logic pd_req;     // bit 7
        logic wk_flag;    // bit 6
        logic wk_ie;      // bit 5
        logic dly_en;     // bit 4
        logic lirc_on;    // bit 3
        logic hirc_on;    // bit 2
        logic lxt_on;     // bit 1
        logic hxt_on;     // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam logic [CTRL_W-1:0] CTRL_RST = 10'h204;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_WAIT_SLEEP = 2'd1,
        ST_PDN        = 2'd2,
        ST_WAKE_DLY   = 2'd3
    } pdn_state_e;

    typedef struct packed {
        pdn_state_e state;
        logic       rdy;
    } fsm_t;

endpackage

// File: rtl/pdn_wake_sync.sv
module pdn_wake_sync #(
    parameter int N_WAKE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_WAKE-1:0] wake_evt_i,
    output logic              wake_o
);
    typedef struct packed {
        logic [N_WAKE-1:0] s1;
        logic [N_WAKE-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = wake_evt_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign wake_o = |sync_q.s2;

endmodule

// File: rtl/pdn_ctrl_regs.sv
module pdn_ctrl_regs
    import pdn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic              unlock_i,
    input  logic              set_flag_i,
    input  logic              clr_req_i,
    output ctrl_t             ctrl_o
);
    ctrl_t ctrl_d, ctrl_q;
    ctrl_t wr_w;

    assign wr_w = ctrl_t'(wr_data_i);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en_i && unlock_i) begin
            ctrl_d         = wr_w;
            ctrl_d.wk_flag = ctrl_q.wk_flag;
        end
        if (wr_en_i && wr_w.wk_flag) ctrl_d.wk_flag = 1'b0;
        if (set_flag_i)              ctrl_d.wk_flag = 1'b1;
        if (clr_req_i)               ctrl_d.pd_req  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= ctrl_t'(CTRL_RST);
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

    assert_locked_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !unlock_i && !clr_req_i) |=>
        $stable({ctrl_q.src_hirc, ctrl_q.wait_cpu, ctrl_q.pd_req, ctrl_q.wk_ie,
                 ctrl_q.dly_en, ctrl_q.lirc_on, ctrl_q.hirc_on, ctrl_q.lxt_on,
                 ctrl_q.hxt_on}));

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag_i |=> ctrl_q.wk_flag);

endmodule

// File: rtl/pdn_dly_timer.sv
module pdn_dly_timer #(
    parameter int DLY_LONG  = 4096,
    parameter int DLY_SHORT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    input  logic src_hirc_i,
    input  logic hxt_tick_i,
    input  logic hirc_tick_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(DLY_LONG + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             tick;

    assign tick = src_hirc_i ? hirc_tick_i : hxt_tick_i;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = src_hirc_i ? CNT_W'(DLY_SHORT) : CNT_W'(DLY_LONG);
        else if (run_i && tick && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = run_i && tick && (cnt_q <= CNT_W'(1));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DLY_LONG));

    assert_no_tick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick && !start_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pdn_seq.sv
module pdn_seq
    import pdn_pkg::*;
#(
    parameter int N_WAKE    = 4,
    parameter int DLY_LONG  = 4096,
    parameter int DLY_SHORT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              unlock,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              cpu_sleep,
    input  logic [N_WAKE-1:0] wake_evt,
    input  logic              hxt_tick,
    input  logic              hirc_tick,
    output logic              hxt_en,
    output logic              lxt_en,
    output logic              hirc_en,
    output logic              lirc_en,
    output logic              pll_en,
    output logic              sysclk_en,
    output logic              sysclk_rdy,
    output logic              wake_irq
);
    ctrl_t ctrl;
    logic  wake;
    logic  clr_req;
    logic  start_dly;
    logic  dly_done;
    fsm_t  fsm_d, fsm_q;

    pdn_wake_sync #(.N_WAKE(N_WAKE)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_evt_i (wake_evt),
        .wake_o     (wake)
    );

    pdn_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .unlock_i   (unlock),
        .set_flag_i (wake),
        .clr_req_i  (clr_req),
        .ctrl_o     (ctrl)
    );

    pdn_dly_timer #(.DLY_LONG(DLY_LONG), .DLY_SHORT(DLY_SHORT)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_dly),
        .run_i       (fsm_q.state == ST_WAKE_DLY),
        .src_hirc_i  (ctrl.src_hirc),
        .hxt_tick_i  (hxt_tick),
        .hirc_tick_i (hirc_tick),
        .done_o      (dly_done)
    );

    always_comb begin
        fsm_d     = fsm_q;
        clr_req   = 1'b0;
        start_dly = 1'b0;
        case (fsm_q.state)
            ST_RUN: begin
                if (ctrl.pd_req) begin
                    if (ctrl.wait_cpu) begin
                        fsm_d.state = ST_WAIT_SLEEP;
                    end else begin
                        fsm_d.state = ST_PDN;
                        fsm_d.rdy   = 1'b0;
                    end
                end
            end
            ST_WAIT_SLEEP: begin
                if (wake) begin
                    fsm_d.state = ST_RUN;
                    clr_req     = 1'b1;
                end else if (!ctrl.pd_req) begin
                    fsm_d.state = ST_RUN;
                end else if (cpu_sleep) begin
                    fsm_d.state = ST_PDN;
                    fsm_d.rdy   = 1'b0;
                end
            end
            ST_PDN: begin
                if (wake) begin
                    clr_req = 1'b1;
                    if (ctrl.dly_en) begin
                        fsm_d.state = ST_WAKE_DLY;
                        start_dly   = 1'b1;
                    end else begin
                        fsm_d.state = ST_RUN;
                        fsm_d.rdy   = 1'b1;
                    end
                end
            end
            default: begin
                if (dly_done) begin
                    fsm_d.state = ST_RUN;
                    fsm_d.rdy   = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= ST_RUN;
            fsm_q.rdy   <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    logic in_pdn;
    assign in_pdn     = (fsm_q.state == ST_PDN);
    assign hxt_en     = ctrl.hxt_on  && !in_pdn;
    assign hirc_en    = ctrl.hirc_on && !in_pdn;
    assign lxt_en     = ctrl.lxt_on;
    assign lirc_en    = ctrl.lirc_on;
    assign pll_en     = !in_pdn;
    assign sysclk_en  = (fsm_q.state == ST_RUN) || (fsm_q.state == ST_WAIT_SLEEP);
    assign sysclk_rdy = fsm_q.rdy;
    assign wake_irq   = ctrl.wk_flag && ctrl.wk_ie;
    assign rd_data    = ctrl;

    assert_direct_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_RUN && ctrl.pd_req && !ctrl.wait_cpu) |=> (fsm_q.state == ST_PDN));

    assert_wait_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_WAIT_SLEEP && !cpu_sleep) |=> (fsm_q.state != ST_PDN));

    assert_req_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_PDN && wake) |=> !ctrl.pd_req);

    assert_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_WAIT_SLEEP && wake) |=> (fsm_q.state == ST_RUN && !ctrl.pd_req));

endmodule

// File: tb/pdn_seq_tb_top.sv
module pdn_seq_tb_top;
    localparam int NW = 4;
    localparam int LONG_N = 4096;
    localparam int SHORT_N = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [9:0]    wr_data = '0;
    logic          unlock = 1'b0;
    logic [9:0]    rd_data;
    logic          cpu_sleep = 1'b0;
    logic [NW-1:0] wake_evt = '0;
    logic          hxt_tick = 1'b0;
    logic          hirc_tick = 1'b0;
    logic          hxt_en, lxt_en, hirc_en, lirc_en, pll_en, sysclk_en, sysclk_rdy, wake_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pdn_seq #(.N_WAKE(NW), .DLY_LONG(LONG_N), .DLY_SHORT(SHORT_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .unlock(unlock),
        .rd_data(rd_data), .cpu_sleep(cpu_sleep), .wake_evt(wake_evt),
        .hxt_tick(hxt_tick), .hirc_tick(hirc_tick), .hxt_en(hxt_en), .lxt_en(lxt_en),
        .hirc_en(hirc_en), .lirc_en(lirc_en), .pll_en(pll_en), .sysclk_en(sysclk_en),
        .sysclk_rdy(sysclk_rdy), .wake_irq(wake_irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [9:0] d, input logic u);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; unlock = u;
        @(negedge clk);
        wr_en = 1'b0; unlock = 1'b0;
    endtask

    task automatic pulse_wake(input int bitn);
        @(negedge clk);
        wake_evt = NW'(1) << bitn;
        @(negedge clk);
        wake_evt = '0;
    endtask

    task automatic measure_delay(input string req, input int exp);
        int n = 0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            n++;
            if (sysclk_en) break;
        end
        chk(req, n, exp);
        chk(req, int'(sysclk_rdy), 1);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R12 reset state
        chk("R12", int'(rd_data), 'h204);
        chk("R12", int'(sysclk_en), 1);
        chk("R12", int'(hirc_en), 1);
        chk("R12", int'(hxt_en), 0);
        chk("R9", int'(wake_irq), 0);

        // R10 locked write ignored
        wr(10'h3BF, 1'b0);
        chk("R10", int'(rd_data), 'h204);
        wr(10'h20F, 1'b1);
        chk("R10", int'(rd_data), 'h20F);
        chk("R4", int'(hxt_en), 1);

        // R1/R4/R7/R3/R8 sweep over every wake line
        for (int i = 0; i < NW; i++) begin
            wr(10'h28F, 1'b1);
            cyc(3);
            chk("R1", int'(sysclk_en), 0);
            chk("R4", int'({hxt_en, hirc_en, pll_en}), 0);
            chk("R4", int'({lxt_en, lirc_en}), 3);
            chk("R4", int'(sysclk_rdy), 0);
            pulse_wake(i);
            cyc(5);
            chk("R7", int'(sysclk_en), 1);
            chk("R7", int'(sysclk_rdy), 1);
            chk("R3", int'(rd_data[7]), 0);
            chk("R8", int'(rd_data[6]), 1);
            chk("R9", int'(wake_irq), 0);
            wr(10'h040, 1'b0);
            chk("R8", int'(rd_data), 'h20F);
        end

        // R9 interrupt follows flag and enable
        wr(10'h22F, 1'b1);
        pulse_wake(1);
        cyc(4);
        chk("R9", int'(wake_irq), 1);
        wr(10'h040, 1'b0);
        chk("R9", int'(wake_irq), 0);

        // R2 wait for processor idle
        wr(10'h3AF, 1'b1);
        cyc(6);
        chk("R2", int'(sysclk_en), 1);
        cpu_sleep = 1'b1;
        cyc(3);
        chk("R2", int'(sysclk_en), 0);
        cpu_sleep = 1'b0;
        pulse_wake(2);
        cyc(5);
        chk("R2", int'(sysclk_en), 1);
        wr(10'h040, 1'b0);

        // R11 wake during wait cancels entry
        wr(10'h3AF, 1'b1);
        cyc(3);
        pulse_wake(3);
        cyc(5);
        chk("R11", int'(rd_data[7]), 0);
        cpu_sleep = 1'b1;
        cyc(5);
        chk("R11", int'(sysclk_en), 1);
        cpu_sleep = 1'b0;
        wr(10'h040, 1'b0);

        // R5 crystal source stabilisation
        wr(10'h09F, 1'b1);
        cyc(3);
        chk("R5", int'(sysclk_en), 0);
        hirc_tick = 1'b1;
        pulse_wake(0);
        cyc(50);
        chk("R6", int'(sysclk_en), 0);
        chk("R6", int'(pll_en), 1);
        hxt_tick = 1'b1;
        measure_delay("R5", LONG_N);
        hxt_tick = 1'b0; hirc_tick = 1'b0;

        // R6 RC source stabilisation
        wr(10'h29F, 1'b1);
        cyc(3);
        chk("R6", int'(sysclk_en), 0);
        hxt_tick = 1'b1;
        pulse_wake(1);
        cyc(50);
        chk("R6", int'(sysclk_en), 0);
        hirc_tick = 1'b1;
        measure_delay("R6", SHORT_N);
        hxt_tick = 1'b0; hirc_tick = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule